// File: doc/BRIEF.md
# Strided Interleaved Bank Controller

The block serves one vector memory operation at a time. An operation is a load or a store of a given number of elements. It starts at a base word address and steps by a programmable stride. The word store is split over a power-of-two number of single-ported banks, and the bank that holds a word is chosen by the low bits of its word address. After each access a bank stays occupied for a fixed number of cycles. The controller issues at most one element access per clock. When the bank an element needs is still occupied, it waits.

The stride therefore sets the throughput. A stride that spreads the elements over at least as many banks as the occupancy time runs at one element per clock. A stride that returns to the same bank sooner stalls. When the stride equals the bank count, every element lands in one bank and each access waits the full occupancy time. Load words come back in element order, each marked by a valid strobe. Store words are taken from a write stream through a valid/ready handshake. A single-cycle done strobe closes every operation.

Top module: `strided_bank_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `rd_valid` and `done` are 0.
- R2: Element k is at word address (base + k*stride) mod 2^AW. Its bank is the low log2(NB) bits of that address and its row is the remaining high bits. A store of element k writes the k-th accepted write word there, and a later load of the same address returns that word.
- R3: A load of N elements raises `rd_valid` exactly N times, and the words arrive in element order.
- R4: Acceptance happens on the clock edge where `req_valid` and `req_ready` are both 1. When the elements of an operation hit at least BUSY distinct banks in rotation (stride 1, 2 or 3 with NB=8, BUSY=4), element k is issued on edge k+1 after acceptance, and `done` appears after edge N.
- R5: Two accesses to the same bank are at least BUSY clock edges apart. With stride NB, the done strobe of an N-element operation appears after edge 1+(N-1)*BUSY counted from acceptance.
- R6: With a partial-conflict stride (stride 4 with NB=8 gives two banks), each element issues at the first edge where its bank is free and no earlier element is still pending.
- R7: `done` is high for one cycle, right after the edge that issued the last element. For a load, it comes in the same cycle as the last `rd_valid`.
- R8: `req_ready` is 0 from acceptance of a non-empty operation until its last element is issued. A `req_valid` seen during that time is ignored.
- R9: An operation with count 0 makes no access and raises `done` right after its acceptance edge.
- R10: A store element issues only on an edge where `wr_valid` and `wr_ready` are both 1. While `wr_valid` is 0, the store waits and consumes no write word.
- R11: Bank occupancy carries over from one operation to the next. A new operation can be accepted in the cycle that `done` is high. Its first element, if it targets a bank the previous operation has just used, waits until that bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request present |
| req_ready | output | 1 | Controller idle; request taken on this edge |
| req_base | input | AW | First element word address |
| req_stride | input | AW | Word distance between consecutive elements |
| req_count | input | CW | Number of elements |
| req_write | input | 1 | 1 = store, 0 = load |
| wr_valid | input | 1 | Write word present |
| wr_ready | output | 1 | Write word consumed on this edge |
| wr_data | input | DW | Write word |
| rd_valid | output | 1 | Load word present |
| rd_data | output | DW | Load word, in element order |
| done | output | 1 | One-cycle end-of-operation strobe |

## Verification
Two things can land in one cycle: the last load word with its done strobe, and the acceptance of the next operation. The bench starts a second operation in the very cycle the first one's done strobe is seen. The second operation targets the bank the first has just used. The bench checks that `req_ready`, `done` and `rd_valid` are high together, and that the first element of the second operation is held back by exactly the remaining occupancy of that bank, measured in edges from its acceptance.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic [0:0] {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_kind_e;

    // width of a down-counter that must hold busy-1
    function automatic int occ_width(input int busy);
        return (busy > 2) ? $clog2(busy) : 1;
    endfunction

endpackage

// File: rtl/sbc_bank_timers.sv
module sbc_bank_timers #(
    parameter int NB   = 8,
    parameter int BUSY = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] hit,
    output logic [NB-1:0] free
);
    localparam int CTW = sbc_pkg::occ_width(BUSY);
    localparam logic [CTW-1:0] RELOAD = CTW'(BUSY - 1);

    for (genvar b = 0; b < NB; b++) begin : g_timer
        logic [CTW-1:0] occ_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q <= '0;
            end else if (hit[b]) begin
                occ_q <= RELOAD;
            end else if (occ_q != '0) begin
                occ_q <= occ_q - 1'b1;
            end
        end

        assign free[b] = (occ_q == '0);
    end
endmodule

// File: rtl/sbc_bank_array.sv
module sbc_bank_array #(
    parameter int NB = 8,
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic [NB-1:0]           en,
    input  logic [NB-1:0]           we,
    input  logic [AW-$clog2(NB)-1:0] row,
    input  logic [DW-1:0]           wdata,
    output logic [NB-1:0][DW-1:0]   rdata
);
    localparam int LB    = $clog2(NB);
    localparam int RW    = AW - LB;
    localparam int DEPTH = 1 << RW;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];
        logic [DW-1:0] q;

        always_ff @(posedge clk) begin
            if (en[b]) begin
                if (we[b]) begin
                    mem[row] <= wdata;
                end else begin
                    q <= mem[row];
                end
            end
        end

        assign rdata[b] = q;
    end
endmodule

// File: rtl/sbc_seq.sv
module sbc_seq #(
    parameter int AW = 8,
    parameter int CW = 8,
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_stride,
    input  logic [CW-1:0] req_count,
    input  logic          req_write,
    input  logic [NB-1:0] bank_free,
    input  logic          wr_valid,
    output logic          wr_ready,
    output logic          iss_en,
    output logic          iss_we,
    output logic [AW-1:0] iss_addr,
    output logic          fin
);
    import sbc_pkg::*;
    localparam int LB = $clog2(NB);

    seq_state_e    state_q;
    op_kind_e      kind_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] stride_q;
    logic [CW-1:0] left_q;

    logic          accept;
    logic          tgt_free;
    logic          data_ok;
    logic          last;

    assign accept    = req_valid && (state_q == SEQ_IDLE);
    assign req_ready = (state_q == SEQ_IDLE);
    assign tgt_free  = bank_free[addr_q[LB-1:0]];
    assign data_ok   = (kind_q == OP_LOAD) || wr_valid;
    assign last      = (left_q == CW'(1));

    assign iss_en   = (state_q == SEQ_RUN) && tgt_free && data_ok;
    assign iss_we   = (kind_q == OP_STORE);
    assign iss_addr = addr_q;
    assign wr_ready = (state_q == SEQ_RUN) && (kind_q == OP_STORE) && tgt_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            kind_q   <= OP_LOAD;
            addr_q   <= '0;
            stride_q <= '0;
            left_q   <= '0;
            fin      <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (accept) begin
                kind_q   <= req_write ? OP_STORE : OP_LOAD;
                addr_q   <= req_base;
                stride_q <= req_stride;
                left_q   <= req_count;
                if (req_count == '0) begin
                    fin <= 1'b1;
                end else begin
                    state_q <= SEQ_RUN;
                end
            end else if (iss_en) begin
                addr_q <= addr_q + stride_q;
                left_q <= left_q - 1'b1;
                if (last) begin
                    state_q <= SEQ_IDLE;
                    fin     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/strided_bank_ctrl.sv
module strided_bank_ctrl #(
    parameter int AW   = 8,
    parameter int DW   = 32,
    parameter int CW   = 8,
    parameter int NB   = 8,
    parameter int BUSY = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_stride,
    input  logic [CW-1:0] req_count,
    input  logic          req_write,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    localparam int LB = $clog2(NB);
    localparam int RW = AW - LB;

    logic [NB-1:0]         bank_free;
    logic [NB-1:0]         bank_hit;
    logic [NB-1:0]         bank_we;
    logic [NB-1:0][DW-1:0] bank_rdata;

    logic                  iss_en;
    logic                  iss_we;
    logic [AW-1:0]         iss_addr;
    logic [LB-1:0]         iss_bank;
    logic [RW-1:0]         iss_row;

    logic                  rd_valid_q;
    logic [LB-1:0]         rd_sel_q;

    sbc_seq #(.AW(AW), .CW(CW), .NB(NB)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_base   (req_base),
        .req_stride (req_stride),
        .req_count  (req_count),
        .req_write  (req_write),
        .bank_free  (bank_free),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .iss_en     (iss_en),
        .iss_we     (iss_we),
        .iss_addr   (iss_addr),
        .fin        (done)
    );

    assign iss_bank = iss_addr[LB-1:0];
    assign iss_row  = iss_addr[AW-1:LB];
    assign bank_hit = iss_en ? ({{(NB-1){1'b0}}, 1'b1} << iss_bank) : '0;
    assign bank_we  = iss_we ? bank_hit : '0;

    sbc_bank_timers #(.NB(NB), .BUSY(BUSY)) u_timers (
        .clk  (clk),
        .rst  (rst),
        .hit  (bank_hit),
        .free (bank_free)
    );

    sbc_bank_array #(.NB(NB), .AW(AW), .DW(DW)) u_banks (
        .clk   (clk),
        .en    (bank_hit),
        .we    (bank_we),
        .row   (iss_row),
        .wdata (wr_data),
        .rdata (bank_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_sel_q   <= '0;
        end else begin
            rd_valid_q <= iss_en && !iss_we;
            if (iss_en) begin
                rd_sel_q <= iss_bank;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = bank_rdata[rd_sel_q];
endmodule

// File: rtl/sbc_chk.sv
module sbc_chk #(
    parameter int NB   = 8,
    parameter int BUSY = 4,
    parameter int CW   = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [CW-1:0] req_count,
    input logic          wr_valid,
    input logic          rd_valid,
    input logic          done,
    input logic [NB-1:0] bank_hit,
    input logic [NB-1:0] bank_we
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rd_valid && !done));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_count != '0)) |=> !req_ready);

    // R2
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_hit));

    // R10
    store_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
        (|bank_we) |-> wr_valid);

    // R3
    rd_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(|(bank_hit & ~bank_we)));

    for (genvar b = 0; b < NB; b++) begin : g_gap
        logic [15:0] since_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                since_q <= 16'(BUSY);
            end else if (bank_hit[b]) begin
                since_q <= 16'd1;
            end else if (since_q < 16'(BUSY)) begin
                since_q <= since_q + 16'd1;
            end
        end

        // R5
        bank_gap_chk: assert property (@(posedge clk) disable iff (rst)
            bank_hit[b] |-> (since_q >= 16'(BUSY)));
    end
endmodule

bind strided_bank_ctrl sbc_chk #(.NB(NB), .BUSY(BUSY), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_count (req_count),
    .wr_valid  (wr_valid),
    .rd_valid  (rd_valid),
    .done      (done),
    .bank_hit  (bank_hit),
    .bank_we   (bank_we)
);

// File: tb/strided_bank_ctrl_tb.sv
`timescale 1ns/1ps
module strided_bank_ctrl_tb;
    localparam int AW   = 8;
    localparam int DW   = 32;
    localparam int CW   = 8;
    localparam int NB   = 8;
    localparam int BUSY = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_stride = '0;
    logic [CW-1:0] req_count = '0;
    logic          req_write = 1'b0;
    logic          wr_valid;
    logic          wr_ready;
    logic [DW-1:0] wr_data;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          done;

    always #2.5 clk = ~clk;

    strided_bank_ctrl #(.AW(AW), .DW(DW), .CW(CW), .NB(NB), .BUSY(BUSY)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_stride(req_stride),
        .req_count(req_count), .req_write(req_write),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    int total = 0;
    int bad   = 0;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // write stream source
    logic [DW-1:0] wq [WORDS];
    int            wq_idx = 0;
    logic          wr_en = 1'b1;
    assign wr_valid = wr_en;
    assign wr_data  = wq[wq_idx];
    always @(posedge clk) if (wr_valid && wr_ready) wq_idx <= wq_idx + 1;

    // output monitor
    logic [DW-1:0] rd_got [WORDS];
    int rd_n = 0;
    int done_n = 0;
    int done_cyc = 0;
    int last_rd_cyc = -1;
    int triple_seen = 0;
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_got[rd_n % WORDS] = rd_data;
            rd_n = rd_n + 1;
            last_rd_cyc = cyc;
        end
        if (done) begin
            done_n = done_n + 1;
            done_cyc = cyc;
            if (req_ready && rd_valid) triple_seen = triple_seen + 1;
        end
    end

    logic [DW-1:0] ref_mem [WORDS];

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int addr_of(input int base, input int stride, input int k);
        return (base + k * stride) % WORDS;
    endfunction

    // issue edges measured from acceptance, from the occupancy rule alone
    function automatic int exp_lat(input int base, input int stride, input int n);
        int fr [NB];
        int t;
        int last;
        for (int i = 0; i < NB; i++) fr[i] = 0;
        t = 1;
        last = 0;
        for (int k = 0; k < n; k++) begin
            int b;
            b = addr_of(base, stride, k) % NB;
            if (t < fr[b]) t = fr[b];
            fr[b] = t + BUSY;
            last = t;
            t++;
        end
        return last;
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
        #1;
    endtask

    // caller stands just after a falling edge
    task automatic run_req(input int base, input int stride, input int cnt,
                           input bit wr, output int lat);
        int snap;
        int acc;
        int guard;
        snap = done_n;
        while (!req_ready) begin @(negedge clk); #1; end
        req_base   = AW'(base);
        req_stride = AW'(stride);
        req_count  = CW'(cnt);
        req_write  = wr;
        req_valid  = 1'b1;
        @(negedge clk); #1;
        acc = cyc;
        req_valid = 1'b0;
        guard = 0;
        while (done_n == snap && guard < 5000) begin
            @(negedge clk); #1;
            guard++;
        end
        lat = done_cyc - acc;
    endtask

    task automatic check_load(input string tag, input int base, input int stride, input int n);
        for (int k = 0; k < n; k++) begin
            chk(tag, rd_got[k], ref_mem[addr_of(base, stride, k)]);
        end
    endtask

    task automatic t_reset();
        chk("R1 req_ready at reset", req_ready, 1);
        chk("R1 rd_valid at reset", rd_valid, 0);
        chk("R1 done at reset", done, 0);
    endtask

    task automatic t_fill();
        int lat;
        for (int k = 0; k < WORDS; k++) begin
            wq[k] = 32'h5A00_0000 ^ (k * 32'h0001_0103);
            ref_mem[k] = wq[k];
        end
        wq_idx = 0;
        run_req(0, 1, WORDS - 1, 1'b1, lat);
        chk("R4 unit-stride store latency", lat, WORDS - 1);
        chk("R10 store words consumed", wq_idx, WORDS - 1);
        settle();
        wq_idx = WORDS - 1;
        run_req(WORDS - 1, 1, 1, 1'b1, lat);
        settle();
    endtask

    task automatic t_load(input string tag, input int base, input int stride, input int n);
        int lat;
        rd_n = 0;
        run_req(base, stride, n, 1'b0, lat);
        chk({tag, " latency"}, lat, exp_lat(base, stride, n));
        chk("R3 load word count", rd_n, n);
        chk("R7 done with last load word", last_rd_cyc, done_cyc);
        check_load({tag, " R2 R3 data"}, base, stride, n);
        settle();
    endtask

    task automatic t_zero();
        int lat;
        int rd0;
        rd0 = rd_n;
        run_req(5, 1, 0, 1'b0, lat);
        chk("R9 zero-count done latency", lat, 0);
        settle();
        chk("R9 zero-count no load word", rd_n, rd0);
    endtask

    task automatic t_busy_ignore();
        int snap;
        int lat;
        snap = done_n;
        rd_n = 0;
        run_req(3, NB, 4, 1'b0, lat);
        chk("R5 same-bank latency", lat, 1 + 3 * BUSY);
        // now a request while busy
        req_base = 8'd0; req_stride = 8'd1; req_count = 8'd5; req_write = 1'b0;
        snap = done_n;
        rd_n = 0;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        // this one was accepted (idle); issue a second one while it runs
        req_base = 8'd9; req_count = 8'd7;
        req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk("R8 req_ready low while busy", req_ready, 0);
            @(negedge clk); #1;
        end
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        chk("R8 ignored request made no words", rd_n, 5);
        chk("R8 ignored request made no done", done_n - snap, 1);
        check_load("R8 R2 data of accepted request", 0, 1, 5);
        settle();
    endtask

    task automatic t_store_stall();
        int snap;
        int y;
        int lat;
        for (int k = 0; k < 4; k++) wq[k] = 32'hC0DE_0000 + k * 32'h11;
        wq_idx = 0;
        wr_en = 1'b0;
        snap = done_n;
        req_base = 8'd40; req_stride = 8'd5; req_count = 8'd4; req_write = 1'b1;
        req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk("R10 no done without write data", done_n, snap);
        chk("R10 no write word taken", wq_idx, 0);
        chk("R10 wr_ready offered", wr_ready, 1);
        wr_en = 1'b1;
        y = cyc;
        while (done_n == snap) begin @(negedge clk); #1; end
        chk("R10 store completes after data", done_cyc - y, 4);
        for (int k = 0; k < 4; k++) ref_mem[addr_of(40, 5, k)] = wq[k];
        settle();
        rd_n = 0;
        run_req(40, 5, 4, 1'b0, lat);
        check_load("R10 R2 stored words", 40, 5, 4);
        settle();
    endtask

    task automatic t_back_to_back();
        int lat;
        int t0;
        t0 = triple_seen;
        rd_n = 0;
        run_req(0, NB, 2, 1'b0, lat);
        chk("R5 two-element same-bank latency", lat, 1 + BUSY);
        chk("R11 ready, done and load word together", triple_seen - t0, 1);
        rd_n = 0;
        run_req(NB, 1, 1, 1'b0, lat);
        chk("R11 carried-over occupancy delay", lat, BUSY - 1);
        check_load("R11 data after carry-over", NB, 1, 1);
        settle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        @(negedge clk); #1;
        t_reset();
        t_fill();
        t_load("R4 stride 1", 0, 1, 16);
        t_load("R4 stride 2", 1, 2, 12);
        t_load("R4 stride 3", 7, 3, 20);
        t_load("R5 stride NB", 2, NB, 6);
        t_load("R6 stride 4", 0, 4, 8);
        t_load("R6 stride 4 wrap", 250, 4, 9);
        t_zero();
        t_busy_ignore();
        t_store_stall();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule